// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Keyed User Mask

This block collects a set of peripheral interrupt request lines and picks one of them to present to a small processor. Each source has a 4-bit priority level. Software sets these levels through 16-bit priority registers that hold four sources each. Each source also has a mask bit, and software changes it through a pair of byte-wide registers: a set register and a clear register. Both registers act only on the bits written as one.

A user mask level sets the lowest priority the processor will accept. A source must be strictly above that level to win. The user mask register changes only when the written word carries the key value 0xA5 in its top byte, so a stray store cannot lower the threshold. The winning request, its level and its source index come out of a register stage one clock after the inputs change.

Software reaches every register through a plain address, write-data and write-enable bus. Reads are combinational.

Top module: `intc_top`

## Requirements
- R1: After reset, every mask bit is 1, every priority is 0, the user mask level is 0 and `irq_req_o` is 0.
- R2: The priority register at byte address 0x00+4*k holds the priority of source 4k+j in bits [4j+3:4j]. A write loads bits [15:0]. A read returns the register in bits [15:0] with bits [31:16] zero.
- R3: Writing to the mask-set register at 0x40+4*m sets the mask bit of source 8m+b for every written data bit b in [7:0] that is 1. Bits written as 0 are unchanged. A read returns the mask byte in bits [7:0].
- R4: Writing to the mask-clear register at 0x60+4*m clears the mask bit of source 8m+b for every written data bit b that is 1. Bits written as 0 are unchanged. Reads of a mask-clear register return zero.
- R5: The user mask register at 0x80 loads data bits [3:0] only when data bits [31:24] equal 0xA5. Any other write to it has no effect. A read returns the level in bits [3:0] and zero elsewhere.
- R6: A source is eligible when its request line is high, its mask bit is 0 and its priority is strictly greater than the user mask level.
- R7: Among the eligible sources, the one with the highest priority wins. When priorities are equal, the lowest source index wins.
- R8: `irq_req_o`, `irq_level_o` and `irq_src_o` are registered and reflect the request lines and register contents of the previous clock. While no source is eligible, the level and the index are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Request lines, active high, one per source |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable, one write per cycle |
| rdata_o | output | 32 | Read data for addr_i |
| irq_req_o | output | 1 | An eligible source exists |
| irq_level_o | output | 4 | Priority of the winning source |
| irq_src_o | output | $clog2(N_SRC) | Index of the winning source |

## Verification
The assertions assume that `irq_i` and the bus inputs are stable around the rising edge, and that each write lasts exactly one enabled cycle. The bench changes request lines and bus inputs only on the falling edge, and it drops `we_i` after one cycle. It holds the inputs steady for two cycles before it compares the registered outputs with its model. The random writes hit only the mapped addresses. Half of the user-mask writes carry a wrong key, so the ignored path is exercised as often as the accepted one.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] UMASK_KEY = 8'hA5;
  localparam logic [ADDR_W-1:0] PRIO_BASE  = 8'h00;
  localparam logic [ADDR_W-1:0] MSET_BASE  = 8'h40;
  localparam logic [ADDR_W-1:0] MCLR_BASE  = 8'h60;
  localparam logic [ADDR_W-1:0] UMASK_ADDR = 8'h80;
  localparam int SLOT = 4;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      we_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [N_SRC*PRIO_W-1:0]   prio_o,
  output logic [N_SRC-1:0]          mask_o,
  output logic [PRIO_W-1:0]         umask_o
);
  localparam int N_PREG = N_SRC / 4;
  localparam int N_MREG = N_SRC / 8;

  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]        mask_q;
  logic [PRIO_W-1:0]       umask_q;

  for (genvar k = 0; k < N_PREG; k++) begin : g_prio
    localparam logic [ADDR_W-1:0] A = ADDR_W'(PRIO_BASE + SLOT*k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[k*16 +: 16] <= '0;
      else if (we_i && addr_i == A) prio_q[k*16 +: 16] <= wdata_i[15:0];
    end
  end

  for (genvar m = 0; m < N_MREG; m++) begin : g_mask
    localparam logic [ADDR_W-1:0] AS = ADDR_W'(MSET_BASE + SLOT*m);
    localparam logic [ADDR_W-1:0] AC = ADDR_W'(MCLR_BASE + SLOT*m);
    logic [7:0] set_b, clr_b;
    assign set_b = (we_i && addr_i == AS) ? wdata_i[7:0] : 8'h00;
    assign clr_b = (we_i && addr_i == AC) ? wdata_i[7:0] : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[m*8 +: 8] <= 8'hFF;
      else mask_q[m*8 +: 8] <= (mask_q[m*8 +: 8] | set_b) & ~clr_b;
    end
  end

  // keyed write: top byte must carry the key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) umask_q <= '0;
    else if (we_i && addr_i == UMASK_ADDR && wdata_i[31:24] == UMASK_KEY)
      umask_q <= wdata_i[PRIO_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_PREG; k++)
      if (addr_i == ADDR_W'(PRIO_BASE + SLOT*k)) rdata_o[15:0] = prio_q[k*16 +: 16];
    for (int m = 0; m < N_MREG; m++)
      if (addr_i == ADDR_W'(MSET_BASE + SLOT*m)) rdata_o[7:0] = mask_q[m*8 +: 8];
    if (addr_i == UMASK_ADDR) rdata_o[PRIO_W-1:0] = umask_q;
  end

  assign prio_o  = prio_q;
  assign mask_o  = mask_q;
  assign umask_o = umask_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC-1:0]        mask_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       umask_i,
  output logic                    any_o,
  output logic [PRIO_W-1:0]       lvl_o,
  output logic [SRC_W-1:0]        idx_o
);
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend_i[i] && !mask_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > umask_i);
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    lvl_o = '0;
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && prio_i[i*PRIO_W +: PRIO_W] > lvl_o) begin
        lvl_o = prio_i[i*PRIO_W +: PRIO_W];
        idx_o = SRC_W'(i);
      end
    end
    any_o = |elig;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    irq_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_req_o,
  output logic [PRIO_W-1:0]   irq_level_o,
  output logic [SRC_W-1:0]    irq_src_o
);
  logic [N_SRC*PRIO_W-1:0] prio_w;
  logic [N_SRC-1:0]        mask_w;
  logic [PRIO_W-1:0]       umask_w;
  logic                    any_d;
  logic [PRIO_W-1:0]       lvl_d;
  logic [SRC_W-1:0]        idx_d;

  intc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .prio_o(prio_w), .mask_o(mask_w),
    .umask_o(umask_w)
  );

  intc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i(irq_i), .mask_i(mask_w), .prio_i(prio_w), .umask_i(umask_w),
    .any_o(any_d), .lvl_o(lvl_d), .idx_o(idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o   <= 1'b0;
      irq_level_o <= '0;
      irq_src_o   <= '0;
    end else begin
      irq_req_o   <= any_d;
      irq_level_o <= lvl_d;
      irq_src_o   <= idx_d;
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              irq_req_o,
  input logic [PRIO_W-1:0] irq_level_o,
  input logic [SRC_W-1:0]  irq_src_o,
  input logic [N_SRC-1:0]  mask_w,
  input logic [PRIO_W-1:0] umask_w
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_level_o == '0 && irq_src_o == '0)); // R8

  AST_LEVEL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_level_o != '0); // R6

  AST_ABOVE_UMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_level_o > $past(umask_w)); // R6

  AST_WINNER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ($past(irq_i & ~mask_w) >> irq_src_o) & 1); // R6

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == UMASK_ADDR && wdata_i[31:24] != UMASK_KEY) |=> $stable(umask_w)); // R5

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == MSET_BASE) |=> ((mask_w[7:0] & $past(wdata_i[7:0])) == $past(wdata_i[7:0]))); // R3

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == MCLR_BASE) |=> ((mask_w[7:0] & $past(wdata_i[7:0])) == 8'h00)); // R4
endmodule

bind intc_top intc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .we_i(we_i), .irq_req_o(irq_req_o),
  .irq_level_o(irq_level_o), .irq_src_o(irq_src_o),
  .mask_w(mask_w), .umask_w(umask_w)
);

// File: tb/intc_top_test.sv
`timescale 1ns/1ps
module intc_top_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        req;
  logic [3:0]  lvl;
  logic [3:0]  src;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0]   m_prio [N];
  logic [N-1:0] m_mask;
  logic [3:0]   m_um;

  always #10 clk = ~clk;

  intc_top #(.N_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_req_o(req), .irq_level_o(lvl), .irq_src_o(src)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    // model update
    if (a < 8'h10 && a[1:0] == 2'b00)
      for (int j = 0; j < 4; j++) m_prio[a[3:2]*4 + j] = d[j*4 +: 4];
    else if (a == 8'h40 || a == 8'h44) m_mask[(a - 8'h40)*2 +: 8] = m_mask[(a - 8'h40)*2 +: 8] | d[7:0];
    else if (a == 8'h60 || a == 8'h64) m_mask[(a - 8'h60)*2 +: 8] = m_mask[(a - 8'h60)*2 +: 8] & ~d[7:0];
    else if (a == 8'h80 && d[31:24] == 8'hA5) m_um = d[3:0];
  endtask

  function automatic logic [8:0] expect_out();
    logic [3:0] bl = 0;
    logic [3:0] bi = 0;
    for (int i = 0; i < N; i++)
      if (irq[i] && !m_mask[i] && m_prio[i] > m_um && m_prio[i] > bl) begin
        bl = m_prio[i]; bi = 4'(i);
      end
    return {bl != 0, bl, bi};
  endfunction

  task automatic settle_check(string tag);
    @(negedge clk); @(negedge clk);
    check(tag, {23'd0, req, lvl, src}, {23'd0, expect_out()});
  endtask

  task automatic rd_check(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic rd_all(string tag);
    for (int k = 0; k < 4; k++)
      rd_check(tag, 8'(4*k), {16'd0, m_prio[4*k+3], m_prio[4*k+2], m_prio[4*k+1], m_prio[4*k]});
    rd_check(tag, 8'h40, {24'd0, m_mask[7:0]});
    rd_check(tag, 8'h44, {24'd0, m_mask[15:8]});
    rd_check(tag, 8'h60, 32'd0);
    rd_check(tag, 8'h80, {28'd0, m_um});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'd1234);
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    m_mask = '1; m_um = 0;
    #35 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 req", {31'd0, req}, 32'd0);
    rd_all("R1 regs");
    irq = '1;
    settle_check("R1 all masked");

    // R7 tie goes to lowest index
    wr(8'h00, 32'h0000_5000);
    wr(8'h08, 32'h0000_0050);
    wr(8'h60, 32'h0000_00FF);
    wr(8'h64, 32'h0000_00FF);
    irq = 16'h0208;
    settle_check("R7 tie");
    check("R7 tie src", {28'd0, src}, 32'd3);
    wr(8'h08, 32'hFFFF_0070);
    settle_check("R7 higher wins");
    rd_check("R2 upper zero", 8'h08, 32'h0000_0070);
    // R6 strictly above user mask
    wr(8'h80, 32'hA500_0007);
    settle_check("R6 equal level blocked");
    check("R6 none", {31'd0, req}, 32'd0);
    // R5 bad key ignored
    wr(8'h80, 32'hA400_0000);
    rd_check("R5 bad key", 8'h80, 32'd7);
    wr(8'h80, 32'hA500_0006);
    settle_check("R5 key accepted");
    // R3 set mask of source 9
    wr(8'h44, 32'h0000_0002);
    settle_check("R3 masked");
    rd_check("R3 readback", 8'h44, 32'h0000_0002);
    // R4 clear leaves other bits, reads zero
    wr(8'h64, 32'h0000_0001);
    rd_check("R4 zero bit kept", 8'h44, 32'h0000_0002);
    rd_check("R4 clr read", 8'h64, 32'd0);
    // R8 one-cycle latency
    wr(8'h80, 32'hA500_0000);
    wr(8'h44, 32'h0000_0000);
    wr(8'h64, 32'h0000_0002);
    @(negedge clk); @(negedge clk);
    irq = 16'h0200;
    @(negedge clk);
    check("R8 latency", {27'd0, req, lvl}, {27'd0, 1'b1, 4'd7});
    irq = '0;
    @(negedge clk);
    check("R8 idle zero", {23'd0, req, lvl, src}, 32'd0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [31:0] r;
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1: wr(8'(4 * r[4:3]), $urandom);
        3'd2: wr(r[5] ? 8'h44 : 8'h40, {24'd0, 8'($urandom) & 8'($urandom)});
        3'd3, 3'd4: wr(r[5] ? 8'h64 : 8'h60, $urandom);
        3'd5: wr(8'h80, {r[6] ? 8'hA5 : 8'(r[31:24] ^ 8'h01), 20'd0, 4'($urandom)});
        default: irq = 16'($urandom);
      endcase
      settle_check("R6 R7 random");
      if (r[9:7] == 0) rd_all("R2 R3 R4 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule